// File: doc/BRIEF.md
# One-Wire Bus Slot Engine

This block is the bit-level master for one open-drain one-wire line. A host asks for one operation at a time. It can write a 1 slot, write a 0 slot, read one bit, or run a reset with presence detection. The block pulls the line low by asserting `line_oe`, and it releases the line to the external pull-up by dropping `line_oe`. It watches the line through `line_in` and gives back the read bit or a two-bit reset status, together with a one-cycle `done` strobe.

All durations are parameters counted in clock cycles. The defaults suit standard speed on a 1 MHz tick. Each read or reset decision is measured from the first cycle in which the block pulls the line low. A read decides its bit by how soon the line comes back high, and gives up at a deadline. A reset refuses to start on a line that is already low. It also reports a bus error if the line is still low when the reset window ends.

Top module: `ow_slot_master`

## Requirements
- R1: `cmd_ready` is high only while the engine is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Op codes: 00 write 1, 01 write 0, 10 read, 11 reset. A command offered while busy is ignored and is not queued.
- R2: Write 1: `line_oe` is high for T_LOW1 cycles, counted from the cycle after acceptance (index 0). Then `line_oe` drops. `done` pulses and `cmd_ready` returns at index T_SLOT+T_REC.
- R3: Write 0: same as R2, except that the low time is T_LOW0 cycles.
- R4: Read: `line_oe` is high for T_LOWR cycles from index 0. `done` pulses at index T_SLOT+T_REC, and `rd_bit` is valid in that cycle.
- R5: The read bit is 1 when the synchronized line is first seen high, after release, at an index below T_RDV. Otherwise the bit is 0.
- R6: If the line never returns high by index T_RDV+2, the read gives 0 and still completes at index T_SLOT+T_REC.
- R7: A reset that is accepted while the synchronized line is low does not drive the line. It pulses `done` in the next cycle with status 11.
- R8: Reset: `line_oe` is high for T_RSTL cycles from index 0. `done` pulses at index T_RSTL+T_RSTH, and `status` is valid in that cycle.
- R9: The presence sample is taken at index T_RSTL+T_PDH+T_PDL/2. A low sample gives status 01, and a high sample gives status 00. The code 10 never occurs.
- R10: The line is sampled again at index T_RSTL+T_RSTH-1. If it is low, the status is 11, whatever the presence sample was.
- R11: `line_in` reaches the decisions through a two-flop synchronizer, so a decision made at index j uses the pin value from index j-2. Out of reset, `cmd_ready` is 1 and `line_oe`, `done`, `rd_bit` and `status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Operation code (R1) |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| done | output | 1 | One-cycle completion strobe |
| rd_bit | output | 1 | Result of the last read slot |
| status | output | 2 | Result of the last reset: 00 none, 01 presence, 11 bus error |
| line_oe | output | 1 | High pulls the line low |
| line_in | input | 1 | Sensed line level |

## Verification
Every result is due at a fixed index, counted from the first low cycle after the accepting edge:
- writes and reads end at index T_SLOT+T_REC;
- a normal reset ends at index T_RSTL+T_RSTH;
- a reset rejected by the pre-check ends one cycle after acceptance.

The bench models a target device as a low-pulling window given in slot indices. From that window and the two-cycle synchronizer delay it works out, before the command is issued, which pin values the read and presence decisions will see. It compares `line_oe`, `done` and `cmd_ready` at every falling edge, and it checks the results at the due index. Boundary cases are tested on both sides: a read hold that lands one index before or one index after the T_RDV limit, and a presence pulse that ends just before or just at the sampled index.

// File: rtl/ow_slot_master.sv
module ow_slot_master #(
  parameter int T_RSTL = 480,
  parameter int T_RSTH = 480,
  parameter int T_PDH  = 30,
  parameter int T_PDL  = 120,
  parameter int T_LOW1 = 6,
  parameter int T_LOW0 = 60,
  parameter int T_LOWR = 6,
  parameter int T_RDV  = 15,
  parameter int T_SLOT = 60,
  parameter int T_REC  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       cmd_ready,
  output logic       done,
  output logic       rd_bit,
  output logic [1:0] status,
  output logic       line_oe,
  input  logic       line_in
);
  localparam int SLOT_END = T_SLOT + T_REC;
  localparam int RST_END  = T_RSTL + T_RSTH;
  localparam int PRES_AT  = T_RSTL + T_PDH + T_PDL / 2;
  localparam int MAXC     = (RST_END > SLOT_END) ? RST_END : SLOT_END;
  localparam int CW       = $clog2(MAXC + 1);

  localparam logic [1:0] OP_W1 = 2'b00;
  localparam logic [1:0] OP_W0 = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_RS = 2'b11;

  logic          busy, decided, pres_q;
  logic [1:0]    op_q, sync;
  logic [CW-1:0] cnt, low_last, end_last;
  logic          line_s;

  assign line_s    = sync[1];
  assign cmd_ready = !busy;
  assign end_last  = (op_q == OP_RS) ? CW'(RST_END - 1) : CW'(SLOT_END - 1);

  always_comb begin
    unique case (op_q)
      OP_W1:   low_last = CW'(T_LOW1 - 1);
      OP_W0:   low_last = CW'(T_LOW0 - 1);
      OP_RD:   low_last = CW'(T_LOWR - 1);
      default: low_last = CW'(T_RSTL - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      decided <= 1'b0;
      pres_q  <= 1'b0;
      op_q    <= OP_W1;
      sync    <= 2'b11;
      cnt     <= '0;
      line_oe <= 1'b0;
      done    <= 1'b0;
      rd_bit  <= 1'b0;
      status  <= 2'b00;
    end else begin
      done <= 1'b0;
      sync <= {sync[0], line_in};
      if (cmd_valid && !busy) begin
        if (cmd_op == OP_RS && !line_s) begin
          done   <= 1'b1;
          status <= 2'b11;
        end else begin
          busy    <= 1'b1;
          op_q    <= cmd_op;
          cnt     <= '0;
          line_oe <= 1'b1;
          decided <= 1'b0;
        end
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == low_last) line_oe <= 1'b0;
        if (op_q == OP_RD && !decided && cnt >= CW'(T_LOWR)) begin
          if (line_s) begin
            rd_bit  <= (cnt < CW'(T_RDV));
            decided <= 1'b1;
          end else if (cnt >= CW'(T_RDV + 2)) begin
            rd_bit  <= 1'b0;
            decided <= 1'b1;
          end
        end
        if (op_q == OP_RS && cnt == CW'(PRES_AT)) pres_q <= !line_s;
        if (cnt == end_last) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (op_q == OP_RS) status <= line_s ? {1'b0, pres_q} : 2'b11;
        end
      end
    end
  end
endmodule

module ow_slot_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       cmd_ready,
  input logic       done,
  input logic [1:0] status,
  input logic       line_oe,
  input logic       line_s
);
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !line_oe);

  p_drive_on_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> $past(cmd_valid && cmd_ready));

  p_done_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  p_slot_starts_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op != 2'b11) |=> line_oe);

  p_precheck_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'b11 && !line_s) |=>
      (done && status == 2'b11 && !line_oe));

  p_status_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status != 2'b10);
endmodule

bind ow_slot_master ow_slot_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_ready(cmd_ready), .done(done), .status(status),
  .line_oe(line_oe), .line_s(line_s)
);

// File: tb/tb_ow_slot_master.sv
`timescale 1ns/1ps
module tb_ow_slot_master;
  localparam int T_RSTL = 480, T_RSTH = 480, T_PDH = 30, T_PDL = 120;
  localparam int T_LOW1 = 6, T_LOW0 = 60, T_LOWR = 6, T_RDV = 15;
  localparam int T_SLOT = 60, T_REC = 5;
  localparam int NEVER = 1000000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic       cmd_ready, done, rd_bit, line_oe, line_in;
  logic [1:0] status;
  logic       slave_low = 1'b0;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;
  assign line_in = !(line_oe || slave_low);

  ow_slot_master #(
    .T_RSTL(T_RSTL), .T_RSTH(T_RSTH), .T_PDH(T_PDH), .T_PDL(T_PDL),
    .T_LOW1(T_LOW1), .T_LOW0(T_LOW0), .T_LOWR(T_LOWR), .T_RDV(T_RDV),
    .T_SLOT(T_SLOT), .T_REC(T_REC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .done(done), .rd_bit(rd_bit), .status(status),
    .line_oe(line_oe), .line_in(line_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit line_at(input int k, input int tlow,
                                 input int lo_from, input int lo_to);
    return !(k >= 0 && k < tlow) && !(k >= lo_from && k < lo_to);
  endfunction

  task automatic run_op(input logic [1:0] op, input int lo_from, input int lo_to,
                        input int inject_k, input string req);
    int tlow, tot;
    logic exp_bit;
    logic [1:0] exp_st;
    logic pres, err;
    tlow = (op == 2'b00) ? T_LOW1 : (op == 2'b01) ? T_LOW0 :
           (op == 2'b10) ? T_LOWR : T_RSTL;
    tot  = (op == 2'b11) ? T_RSTL + T_RSTH : T_SLOT + T_REC;
    exp_bit = 1'b0;
    for (int j = T_LOWR; j <= T_RDV + 2; j++) begin
      if (line_at(j - 2, tlow, lo_from, lo_to)) begin
        exp_bit = (j < T_RDV);
        break;
      end
    end
    pres = !line_at(T_RSTL + T_PDH + T_PDL / 2 - 2, tlow, lo_from, lo_to);
    err  = !line_at(T_RSTL + T_RSTH - 3, tlow, lo_from, lo_to);
    exp_st = err ? 2'b11 : {1'b0, pres};
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    for (int k = 0; k <= tot + 1; k++) begin
      @(negedge clk);
      if (k == 0) cmd_valid = 1'b0;
      chk(line_oe == (k < tlow), req, "line_oe", int'(line_oe), int'(k < tlow));
      chk(done == (k == tot), req, "done", int'(done), int'(k == tot));
      chk(cmd_ready == (k >= tot), "R1", "cmd_ready", int'(cmd_ready), int'(k >= tot));
      if (k == tot && op == 2'b10)
        chk(rd_bit == exp_bit, req, "rd_bit", int'(rd_bit), int'(exp_bit));
      if (k == tot && op == 2'b11)
        chk(status == exp_st, req, "status", int'(status), int'(exp_st));
      slave_low = (k >= lo_from && k < lo_to);
      if (k == inject_k) begin cmd_valid = 1'b1; cmd_op = 2'b11; end
      if (k == inject_k + 1) cmd_valid = 1'b0;
    end
  endtask

  task automatic settle(input logic lvl);
    slave_low = lvl;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R11", "reset cmd_ready", int'(cmd_ready), 1);
    chk(line_oe == 1'b0, "R11", "reset line_oe", int'(line_oe), 0);
    chk(done == 1'b0, "R11", "reset done", int'(done), 0);
    chk(status == 2'b00, "R11", "reset status", int'(status), 0);
    chk(rd_bit == 1'b0, "R11", "reset rd_bit", int'(rd_bit), 0);

    run_op(2'b00, 0, 0, -5, "R2");
    run_op(2'b01, 0, 0, 20, "R3");
    run_op(2'b10, 0, 0, -5, "R4");
    run_op(2'b10, 0, 12, -5, "R5");
    run_op(2'b10, 0, 13, -5, "R11");
    run_op(2'b10, 0, 9, -5, "R5");
    run_op(2'b10, 0, NEVER, -5, "R6");
    settle(1'b0);

    run_op(2'b11, 510, 630, -5, "R9");
    run_op(2'b11, 0, 0, -5, "R8");
    run_op(2'b11, 510, 568, -5, "R9");
    run_op(2'b11, 510, 569, -5, "R11");
    run_op(2'b11, 510, NEVER, -5, "R10");

    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'b11;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(done == 1'b1, "R7", "precheck done", int'(done), 1);
    chk(status == 2'b11, "R7", "precheck status", int'(status), 3);
    chk(line_oe == 1'b0, "R7", "precheck line_oe", int'(line_oe), 0);
    chk(cmd_ready == 1'b1, "R7", "precheck cmd_ready", int'(cmd_ready), 1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(line_oe == 1'b0 && done == 1'b0, "R7", "after precheck",
          int'({line_oe, done}), 0);
    end
    settle(1'b0);
    run_op(2'b11, 515, 600, -5, "R9");
    run_op(2'b00, 0, 0, -5, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule